// File: doc/BRIEF.md
# Time-Multiplexed Overrange Status Flag

This block turns short overrange pulses from the left and right audio channels into one active-low status line. That line carries both channel bits, one per half of the frame clock. A reader can latch each channel's state on the matching frame-clock edge. Once a channel is flagged, its bit stays asserted for a fixed number of frames. The number is scaled by the speed mode so that the hold time in wall-clock terms is the same at every sample rate. Slow readers therefore see the event however fast frames arrive.

The bit clock and frame clock come from the serial audio port. They are sampled as synchronous signals in the fabric clock domain. The pin changes only on a detected bit-clock falling edge, at a fixed count of bit-clock periods after each frame-clock transition. That count depends on the serial format. Any new overrange on either channel restarts one shared hold counter, so both bits clear together after a quiet period. The output models an open-drain pin as an ordinary logic output.

Top module: `ovf_flag_mux`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `ovf_n` is 1 and both channel flags are clear.
- R2: After a slot's update point, `ovf_n` is 0 exactly when the flag of the channel assigned to that slot was set at the update point, and 1 otherwise.
- R3: A one-cycle pulse on `ovr_left` (or `ovr_right`) sets that channel's flag on the next clock and leaves the other channel's flag as it was.
- R4: With no further overrange, both flags clear on the N-th rising frame-clock edge after the last overrange, where N = BASE_FRAMES << s. The shift s is 0 for `speed`=0 (single), 1 for `speed`=1 (double) and 2 for `speed`=2 (quad). The value `speed`=3 behaves as quad.
- R5: An overrange on either channel reloads the single hold counter, and this extends the hold of both channels' flags.
- R6: With `fmt_i2s`=0 (left-justified), the pin updates on the 1st bit-clock falling edge after a frame-clock transition. After a falling frame-clock edge the pin carries the right flag; after a rising edge it carries the left flag.
- R7: With `fmt_i2s`=1 (I2S), the pin updates on the 2nd bit-clock falling edge after a frame-clock transition. After a rising frame-clock edge the pin carries the right flag; after a falling edge it carries the left flag.
- R8: Between updates the pin holds its value. It is stable from its update point through the following frame-clock edge, up to the next update point.
- R9: A bit-clock falling edge that coincides with a frame-clock transition counts as position zero. Edge positions are counted from there, and the pin never changes on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; all state is registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock, sampled as data |
| lrck | input | 1 | Frame clock, sampled as data; one transition per channel slot |
| fmt_i2s | input | 1 | 1 selects I2S slot timing, 0 selects left-justified |
| speed | input | 2 | Speed mode: 0 single, 1 double, 2 quad, 3 treated as quad |
| ovr_left | input | 1 | Left-channel overrange pulse |
| ovr_right | input | 1 | Right-channel overrange pulse |
| ovf_n | output | 1 | Active-low time-multiplexed overflow status |

## Verification
The bench covers both serial formats at every speed mode value, including the reserved one. For each combination it runs three patterns. With no overrange, the line must stay high. A left-only pulse shows that only the left slots go low, and that the low lasts exactly the scaled frame count for that mode. A right pulse followed a few frames later by a left pulse shows that the second event stretches the hold of the first channel as well. The pin is compared at every bit-clock falling edge of every slot. This separates the one-period and two-period update offsets, the slot-to-channel mapping for each format, and stability across the frame-clock edge.

// File: rtl/ovf_flag_pkg.sv
package ovf_flag_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2,
    SPD_RSVD   = 2'd3
  } speed_e;

  // Left shift applied to the base frame count for a speed mode.
  function automatic logic [1:0] speed_shift(input logic [1:0] spd);
    case (speed_e'(spd))
      SPD_SINGLE: speed_shift = 2'd0;
      SPD_DOUBLE: speed_shift = 2'd1;
      default:    speed_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/ovf_edge_sense.sv
// Synchronises the serial clocks into the fabric domain and reports edges.
module ovf_edge_sense #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic lrck,
  output logic bclk_fall,
  output logic lrck_edge,
  output logic lrck_rise,
  output logic lrck_lvl
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] b_sync;
  logic [SYNC_STAGES-1:0] l_sync;
  logic                   b_prev;
  logic                   l_prev;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            b_sync[i] <= 1'b0;
            l_sync[i] <= 1'b0;
          end else begin
            b_sync[i] <= bclk;
            l_sync[i] <= lrck;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            b_sync[i] <= 1'b0;
            l_sync[i] <= 1'b0;
          end else begin
            b_sync[i] <= b_sync[i-1];
            l_sync[i] <= l_sync[i-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      b_prev <= 1'b0;
      l_prev <= 1'b0;
    end else begin
      b_prev <= b_sync[LAST];
      l_prev <= l_sync[LAST];
    end
  end

  always_comb begin
    bclk_fall = b_prev & ~b_sync[LAST];
    lrck_edge = l_prev ^ l_sync[LAST];
    lrck_rise = ~l_prev & l_sync[LAST];
    lrck_lvl  = l_sync[LAST];
  end

endmodule

// File: rtl/ovf_hold_timer.sv
// Per-channel sticky flags with one shared frame-count hold timer.
module ovf_hold_timer
  import ovf_flag_pkg::*;
#(
  parameter int BASE_FRAMES = 32640,
  parameter int CNT_W       = $clog2(BASE_FRAMES * 4 + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       speed,
  input  logic             ovr_left,
  input  logic             ovr_right,
  input  logic             frame_rise,
  output logic             flag_l,
  output logic             flag_r,
  output logic [CNT_W-1:0] hold_cnt
);
  localparam logic [CNT_W-1:0] BASE_V = CNT_W'(BASE_FRAMES);

  logic [CNT_W-1:0] reload;
  logic             any_ovr;

  always_comb begin
    reload  = BASE_V << speed_shift(speed);
    any_ovr = ovr_left | ovr_right;
  end

  // A pulse that coincides with a frame edge wins: the counter reloads.
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_l   <= 1'b0;
      flag_r   <= 1'b0;
      hold_cnt <= '0;
    end else if (any_ovr) begin
      flag_l   <= flag_l | ovr_left;
      flag_r   <= flag_r | ovr_right;
      hold_cnt <= reload;
    end else if (frame_rise && hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
      if (hold_cnt == CNT_W'(1)) begin
        flag_l <= 1'b0;
        flag_r <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ovf_slot_serializer.sv
// Places the slot's channel flag on the pin a fixed number of bit-clock
// falling edges after each frame-clock transition.
module ovf_slot_serializer #(
  parameter int LJ_LAG  = 1,
  parameter int I2S_LAG = 2,
  parameter int POS_W   = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic fmt_i2s,
  input  logic bclk_fall,
  input  logic lrck_edge,
  input  logic lrck_lvl,
  input  logic flag_l,
  input  logic flag_r,
  output logic ovf_n
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] fall_pos;
  logic [POS_W-1:0] next_pos;
  logic [POS_W-1:0] lag;
  logic             slot_right;

  always_comb begin
    lag      = fmt_i2s ? POS_W'(I2S_LAG) : POS_W'(LJ_LAG);
    next_pos = fall_pos + 1'b1;
  end

  // The position saturates, so there is no update before the first edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      fall_pos   <= POS_MAX;
      slot_right <= 1'b0;
      ovf_n      <= 1'b1;
    end else if (lrck_edge) begin
      fall_pos   <= '0;
      slot_right <= fmt_i2s ? lrck_lvl : ~lrck_lvl;
    end else if (bclk_fall && fall_pos != POS_MAX) begin
      fall_pos <= next_pos;
      if (next_pos == lag) begin
        ovf_n <= ~(slot_right ? flag_r : flag_l);
      end
    end
  end

endmodule

// File: rtl/ovf_flag_mux.sv
module ovf_flag_mux #(
  parameter int BASE_FRAMES = 32640,
  parameter int SYNC_STAGES = 2,
  parameter int LJ_LAG      = 1,
  parameter int I2S_LAG     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bclk,
  input  logic       lrck,
  input  logic       fmt_i2s,
  input  logic [1:0] speed,
  input  logic       ovr_left,
  input  logic       ovr_right,
  output logic       ovf_n
);
  localparam int CNT_W = $clog2(BASE_FRAMES * 4 + 1);
  localparam int POS_W = $clog2((LJ_LAG > I2S_LAG ? LJ_LAG : I2S_LAG) + 2) + 1;

  logic             bclk_fall;
  logic             lrck_edge;
  logic             frame_rise;
  logic             lrck_lvl;
  logic             flag_l;
  logic             flag_r;
  logic [CNT_W-1:0] hold_cnt;

  ovf_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk       (clk),
    .rst       (rst),
    .bclk      (bclk),
    .lrck      (lrck),
    .bclk_fall (bclk_fall),
    .lrck_edge (lrck_edge),
    .lrck_rise (frame_rise),
    .lrck_lvl  (lrck_lvl)
  );

  ovf_hold_timer #(.BASE_FRAMES(BASE_FRAMES), .CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .speed      (speed),
    .ovr_left   (ovr_left),
    .ovr_right  (ovr_right),
    .frame_rise (frame_rise),
    .flag_l     (flag_l),
    .flag_r     (flag_r),
    .hold_cnt   (hold_cnt)
  );

  ovf_slot_serializer #(.LJ_LAG(LJ_LAG), .I2S_LAG(I2S_LAG), .POS_W(POS_W)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .fmt_i2s   (fmt_i2s),
    .bclk_fall (bclk_fall),
    .lrck_edge (lrck_edge),
    .lrck_lvl  (lrck_lvl),
    .flag_l    (flag_l),
    .flag_r    (flag_r),
    .ovf_n     (ovf_n)
  );

endmodule

// File: rtl/ovf_flag_checker.sv
module ovf_flag_checker
  import ovf_flag_pkg::*;
#(
  parameter int BASE_FRAMES = 32640,
  parameter int CNT_W       = 17
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       speed,
  input logic             ovr_left,
  input logic             ovr_right,
  input logic             ovf_n,
  input logic             flag_l,
  input logic             flag_r,
  input logic [CNT_W-1:0] hold_cnt,
  input logic             frame_rise,
  input logic             bclk_fall
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (ovf_n && !flag_l && !flag_r));

  assert_left_sets_R3: assert property (@(posedge clk) disable iff (rst)
    ovr_left |=> flag_l);

  assert_right_sets_R3: assert property (@(posedge clk) disable iff (rst)
    ovr_right |=> flag_r);

  assert_right_kept_on_left_R3: assert property (@(posedge clk) disable iff (rst)
    (ovr_left && !ovr_right && !frame_rise) |=> (flag_r == $past(flag_r)));

  assert_reload_both_R5: assert property (@(posedge clk) disable iff (rst)
    (ovr_left || ovr_right) |=>
      (hold_cnt == (CNT_W'(BASE_FRAMES) << speed_shift($past(speed)))));

  assert_clear_on_last_frame_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(flag_l) || $fell(flag_r)) |->
      ($past(frame_rise) && $past(hold_cnt) == CNT_W'(1)));

  assert_count_tracks_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (hold_cnt != '0) == (flag_l || flag_r));

  assert_pin_moves_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    (ovf_n != $past(ovf_n)) |-> $past(bclk_fall));

endmodule

bind ovf_flag_mux ovf_flag_checker #(.BASE_FRAMES(BASE_FRAMES), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .speed      (speed),
  .ovr_left   (ovr_left),
  .ovr_right  (ovr_right),
  .ovf_n      (ovf_n),
  .flag_l     (flag_l),
  .flag_r     (flag_r),
  .hold_cnt   (hold_cnt),
  .frame_rise (frame_rise),
  .bclk_fall  (bclk_fall)
);

// File: tb/tb_ovf_flag_mux.sv
module tb_ovf_flag_mux;
  localparam int CLK_PERIOD = 10;
  localparam int BHALF      = 6;
  localparam int SLOT_BITS  = 32;
  localparam int BASE       = 2;
  localparam int PULSE_POS  = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bclk = 1'b1;
  logic       lrck = 1'b0;
  logic       fmt_i2s = 1'b0;
  logic [1:0] speed = 2'd0;
  logic       ovr_left = 1'b0;
  logic       ovr_right = 1'b0;
  logic       ovf_n;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  bit    model_l, model_r;
  int    model_cnt;
  bit    cur_exp, prev_exp;
  int    lag;
  string phase_tag;

  ovf_flag_mux #(.BASE_FRAMES(BASE)) dut (
    .clk(clk), .rst(rst), .bclk(bclk), .lrck(lrck), .fmt_i2s(fmt_i2s),
    .speed(speed), .ovr_left(ovr_left), .ovr_right(ovr_right), .ovf_n(ovf_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit got, input bit exp, input string tag, input string what);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d (fmt=%0d speed=%0d)",
               tag, what, got, exp, fmt_i2s, speed);
    end
  endtask

  function automatic int hold_frames(input int spd);
    return BASE << ((spd >= 2) ? 2 : spd);
  endfunction

  // One channel slot: SLOT_BITS bit-clock periods, frame-clock edge at position 0.
  task automatic half_frame(input bit pl, input bit pr);
    for (int k = 0; k < SLOT_BITS; k++) begin
      @(negedge clk);
      bclk = 1'b0;
      if (k == 0) begin
        lrck = ~lrck;
        prev_exp = cur_exp;
        if (lrck == 1'b1 && model_cnt > 0) begin
          model_cnt--;
          if (model_cnt == 0) begin
            model_l = 0;
            model_r = 0;
          end
        end
      end
      if (k == lag) begin
        // R6/R7 slot mapping: LJ low half carries right, I2S high half carries right
        if ((fmt_i2s ? lrck : ~lrck) == 1'b1) cur_exp = ~model_r;
        else                                  cur_exp = ~model_l;
      end
      if (k == PULSE_POS && (pl || pr)) begin
        ovr_left  = pl;
        ovr_right = pr;
        if (pl) model_l = 1;
        if (pr) model_r = 1;
        model_cnt = hold_frames(speed);
        @(negedge clk);
        ovr_left  = 1'b0;
        ovr_right = 1'b0;
        repeat (BHALF - 3) @(negedge clk);
      end else begin
        repeat (BHALF - 2) @(negedge clk);
      end
      if (k == 0)
        check(ovf_n, prev_exp, "R9", "no change on edge-coincident fall");
      else if (k < lag)
        check(ovf_n, prev_exp, "R8", "held across frame edge");
      else if (k == lag)
        check(ovf_n, cur_exp, fmt_i2s ? "R7" : "R6", "update position and channel");
      else
        check(ovf_n, cur_exp, phase_tag, "slot value");
      @(negedge clk);
      bclk = 1'b1;
      repeat (BHALF) @(negedge clk);
    end
  endtask

  task automatic run_halves(input int n);
    for (int i = 0; i < n; i++) half_frame(1'b0, 1'b0);
  endtask

  task automatic run_config(input bit f, input int spd);
    int n;
    @(negedge clk);
    rst = 1'b1;
    fmt_i2s = f;
    speed = 2'(spd);
    lrck = 1'b0;
    bclk = 1'b1;
    model_l = 0; model_r = 0; model_cnt = 0;
    cur_exp = 1; prev_exp = 1;
    lag = f ? 2 : 1;
    repeat (4) @(negedge clk);
    check(ovf_n, 1'b1, "R1", "pin during reset");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(ovf_n, 1'b1, "R1", "pin after reset");
    n = hold_frames(spd);
    phase_tag = "R2";
    run_halves(2);
    phase_tag = "R3";
    half_frame(1'b1, 1'b0);
    run_halves(2);
    phase_tag = "R4";
    run_halves(2 * n + 1);
    phase_tag = "R5";
    half_frame(1'b0, 1'b1);
    run_halves(2);
    half_frame(1'b1, 1'b0);
    run_halves(2 * n + 3);
  endtask

  initial begin
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 4; s++)
        run_config(f[0], s);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule